// File: doc/BRIEF.md
# Target Halt and Single-Step Controller

This block turns an 8-bit control value into the override lines a debug station needs to hold a target microprocessor bus. Each cleared bit asserts one active-low override on the target. One bit holds the target CPU not-ready, which halts it part way through a machine cycle. A second bit asserts jamming of external data onto the CPU input path. Other bits assert target reset, memory write protection, disabling of the CPU data-out drivers, a boot-ROM phantom select, and a keyboard data-ready strobe. A value of 0xFF leaves the target running with no override active.

To single-step, the host first clears the halt bit. It then raises the step bit. Each zero-to-one transition of the step bit, taken while the halt bit is still clear, produces one ready pulse of fixed length. A target machine cycle is 3 to 5 states of 500 ns, so the pulse lets the target finish exactly one machine cycle.

The pulse length is `PULSE_CYCLES` clocks. At elaboration the block checks that this length falls strictly between 500 ns and 1 µs for the stated clock period. The control value comes from a register that lives outside this block.

Top module: `tgt_step_ctrl`

## Requirements
- R1: While reset is held and after its release with `ctrlReg` at 0xFF, every output shows the free-run state: `readyOut`, `jamN`, `tgtResetN`, `wrProtN`, `dataOutDisN`, `phantomN` and `keyReadyN` are all 1, both drive enables are 0, and no pulse is pending.
- R2: When bit 0 of the control value is 0 and no step pulse is active, `readyOut` is 0. When bit 0 is 1, `readyOut` is 1.
- R3: A 0-to-1 change of bit 1 in a cycle where the new bit 0 is 0 drives `readyOut` to 1 for exactly `PULSE_CYCLES` clock cycles, starting one cycle later. `readyOut` then returns to 0.
- R4: A 0-to-1 change of bit 1 in a cycle where the new bit 0 is 1 starts no pulse. A later clearing of bit 0 with bit 1 held at 1 leaves `readyOut` at 0.
- R5: A further 0-to-1 change of bit 1 while a pulse is active is ignored. The pulse keeps its original length.
- R6: A 1-to-0 change of bit 1, or bit 1 held at 1, starts no pulse.
- R7: Bit 2 at 0 drives `jamN` to 0 and `dioDriveEn` to 1. Bit 2 at 1 drives `jamN` to 1 and `dioDriveEn` to 0.
- R8: `tgtResetN` follows bit 3.
- R9: Bit 4 at 0 drives `wrProtN` to 0 and `memWrDriveEn` to 1, so that memory-write is driven low. Bit 4 at 1 reverses both.
- R10: `dataOutDisN` follows bit 5 and `phantomN` follows bit 6.
- R11: `keyReadyN` follows bit 7, so a 0-to-1 change of bit 7 gives a rising edge on `keyReadyN`.
- R12: `PULSE_CYCLES` times `CLK_PERIOD_NS` must lie strictly between 500 and 1000 ns, otherwise elaboration fails.
- R13: Every output responds to a new `ctrlReg` value at the first rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlReg | input | 8 | Control value from the host-loaded register |
| readyOut | output | 1 | Target CPU ready (0 holds the CPU) |
| jamN | output | 1 | Active-low data-jam request |
| dioDriveEn | output | 1 | Enables the data-out register drivers onto the target data bus |
| tgtResetN | output | 1 | Active-low target reset |
| wrProtN | output | 1 | Active-low disable of the target memory-write driver |
| memWrDriveEn | output | 1 | Enables a driver that holds target memory-write low |
| dataOutDisN | output | 1 | Active-low disable of the target CPU data-out drivers |
| phantomN | output | 1 | Active-low boot-ROM phantom select |
| keyReadyN | output | 1 | Active-low keyboard data-ready line |

## Verification
The output-mapping properties compare each output with `ctrlReg` as sampled one edge earlier. They therefore assume the control value is stable across each rising edge and is held at 0xFF throughout reset. The bench keeps to this by changing `ctrlReg` only on falling edges and by holding it at 0xFF while reset is asserted.

The pulse-length property assumes that a run of ready-high cycles under a cleared halt bit comes only from a step pulse. The stimulus keeps to this because each pulse run is preceded by a settled halted state.

// File: rtl/tgt_step_pkg.sv
package tgt_step_pkg;

  // Bit positions inside the control value; the decode depends on them.
  localparam int unsigned CTRL_W      = 8;
  localparam int unsigned BIT_RUN     = 0;
  localparam int unsigned BIT_STEP    = 1;
  localparam int unsigned BIT_JAM     = 2;
  localparam int unsigned BIT_RESET   = 3;
  localparam int unsigned BIT_WRPROT  = 4;
  localparam int unsigned BIT_DOUTDIS = 5;
  localparam int unsigned BIT_PHANTOM = 6;
  localparam int unsigned BIT_KEYRDY  = 7;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PULSE = 1'b1
  } stepState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic start;   // load the pulse counter
    logic dec;     // count down one clock
    logic pulseOn; // ready pulse currently active
  } pulseCmd_t;

endpackage

// File: rtl/tgt_step_fsm.sv
module tgt_step_fsm
  import tgt_step_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runNew,   // incoming run/halt bit
  input  logic      stepNew,  // incoming step bit
  input  logic      stepOld,  // step bit held from the last edge
  input  logic      cntZero,  // pulse counter exhausted
  output pulseCmd_t cmd
);

  stepState_t state, stateNext;
  logic stepRise;
  logic accept;

  // A step request counts only on a rising step bit while the target stays halted.
  assign stepRise = stepNew & ~stepOld;
  assign accept   = stepRise & ~runNew & (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept)  stateNext = ST_PULSE;
      ST_PULSE: if (cntZero) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmd.start   = accept;
    cmd.dec     = (state == ST_PULSE) & ~cntZero;
    cmd.pulseOn = (state == ST_PULSE);
  end

endmodule

// File: rtl/tgt_step_dp.sv
module tgt_step_dp
  import tgt_step_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  pulseCmd_t         cmd,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              cntZero,
  output logic              readyOut,
  output logic              jamN,
  output logic              dioDriveEn,
  output logic              tgtResetN,
  output logic              wrProtN,
  output logic              memWrDriveEn,
  output logic              dataOutDisN,
  output logic              phantomN,
  output logic              keyReadyN
);

  localparam int unsigned CNT_W = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] pulseCnt;

  // Captured control value; resets to the free-run pattern.
  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '1;
    else       ctrlQ <= ctrlReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pulseCnt <= '0;
    else if (cmd.start) pulseCnt <= CNT_LOAD;
    else if (cmd.dec)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign cntZero = (pulseCnt == '0);

  // Each override pin comes straight from one captured bit.
  assign readyOut     = ctrlQ[BIT_RUN] | cmd.pulseOn;
  assign jamN         = ctrlQ[BIT_JAM];
  assign dioDriveEn   = ~ctrlQ[BIT_JAM];
  assign tgtResetN    = ctrlQ[BIT_RESET];
  assign wrProtN      = ctrlQ[BIT_WRPROT];
  assign memWrDriveEn = ~ctrlQ[BIT_WRPROT];
  assign dataOutDisN  = ctrlQ[BIT_DOUTDIS];
  assign phantomN     = ctrlQ[BIT_PHANTOM];
  assign keyReadyN    = ctrlQ[BIT_KEYRDY];

endmodule

// File: rtl/tgt_step_ctrl.sv
module tgt_step_ctrl
  import tgt_step_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned PULSE_CYCLES  = 38,
  parameter int unsigned MIN_PULSE_NS  = 500,
  parameter int unsigned MAX_PULSE_NS  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ctrlReg,
  output logic       readyOut,
  output logic       jamN,
  output logic       dioDriveEn,
  output logic       tgtResetN,
  output logic       wrProtN,
  output logic       memWrDriveEn,
  output logic       dataOutDisN,
  output logic       phantomN,
  output logic       keyReadyN
);

  localparam int unsigned PULSE_NS = PULSE_CYCLES * CLK_PERIOD_NS;

  // R12: the pulse must sit strictly inside the step window.
  generate
    if (PULSE_CYCLES == 0 || PULSE_NS <= MIN_PULSE_NS || PULSE_NS >= MAX_PULSE_NS) begin : g_badPulse
      $error("step pulse of %0d ns lies outside the allowed window", PULSE_NS);
    end
  endgenerate

  pulseCmd_t         cmd;
  logic [CTRL_W-1:0] ctrlQ;
  logic              cntZero;

  tgt_step_fsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .runNew  (ctrlReg[BIT_RUN]),
    .stepNew (ctrlReg[BIT_STEP]),
    .stepOld (ctrlQ[BIT_STEP]),
    .cntZero (cntZero),
    .cmd     (cmd)
  );

  tgt_step_dp #(
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlReg      (ctrlReg),
    .cmd          (cmd),
    .ctrlQ        (ctrlQ),
    .cntZero      (cntZero),
    .readyOut     (readyOut),
    .jamN         (jamN),
    .dioDriveEn   (dioDriveEn),
    .tgtResetN    (tgtResetN),
    .wrProtN      (wrProtN),
    .memWrDriveEn (memWrDriveEn),
    .dataOutDisN  (dataOutDisN),
    .phantomN     (phantomN),
    .keyReadyN    (keyReadyN)
  );

endmodule

// File: rtl/tgt_step_checker.sv
module tgt_step_checker #(
  parameter int unsigned PULSE_CYCLES = 38
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctrlReg,
  input logic       readyOut,
  input logic       jamN,
  input logic       dioDriveEn,
  input logic       tgtResetN,
  input logic       wrProtN,
  input logic       memWrDriveEn,
  input logic       dataOutDisN,
  input logic       phantomN,
  input logic       keyReadyN
);

  localparam int unsigned RUN_W = $clog2(PULSE_CYCLES + 2) + 1;

  logic             prevHalt;
  logic [RUN_W-1:0] highRun;

  // Counts consecutive ready-high cycles taken under a cleared halt bit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHalt <= 1'b0;
      highRun  <= '0;
    end else begin
      prevHalt <= ~ctrlReg[0];
      if (readyOut && prevHalt) highRun <= highRun + 1'b1;
      else                      highRun <= '0;
    end
  end

  a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= RUN_W'(PULSE_CYCLES));

  a_r2_run_ready: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(ctrlReg[0]) |-> readyOut);

  a_r7_jam: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (jamN == $past(ctrlReg[2])) && (dioDriveEn != jamN));

  a_r8_reset: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> tgtResetN == $past(ctrlReg[3]));

  a_r9_wrprot: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (wrProtN == $past(ctrlReg[4])) && (memWrDriveEn != wrProtN));

  a_r10_dout_phantom: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (dataOutDisN == $past(ctrlReg[5])) && (phantomN == $past(ctrlReg[6])));

  a_r11_keyready: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> keyReadyN == $past(ctrlReg[7]));

endmodule

bind tgt_step_ctrl tgt_step_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .ctrlReg      (ctrlReg),
  .readyOut     (readyOut),
  .jamN         (jamN),
  .dioDriveEn   (dioDriveEn),
  .tgtResetN    (tgtResetN),
  .wrProtN      (wrProtN),
  .memWrDriveEn (memWrDriveEn),
  .dataOutDisN  (dataOutDisN),
  .phantomN     (phantomN),
  .keyReadyN    (keyReadyN)
);

// File: tb/tgt_step_ctrl_bench.sv
module tgt_step_ctrl_bench;

  localparam int unsigned CLK_NS = 20;
  localparam int unsigned PULSE  = 38;
  localparam int unsigned NVEC   = 12;

  // {ctrl, expected {ready,jamN,dioEn,rstN,wpN,mwEn,doutN,phN,kbN}}
  localparam logic [16:0] VECS [NVEC] = '{
    {8'hFD, 9'b110110111},
    {8'hFC, 9'b010110111},
    {8'hF8, 9'b001110111},
    {8'hF0, 9'b001010111},
    {8'hE0, 9'b001001111},
    {8'hC0, 9'b001001011},
    {8'h80, 9'b001001001},
    {8'h00, 9'b001001000},
    {8'h7D, 9'b110110110},
    {8'hA9, 9'b101101101},
    {8'h54, 9'b010010010},
    {8'hFD, 9'b110110111}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ctrlReg = 8'hFF;
  logic       readyOut, jamN, dioDriveEn, tgtResetN, wrProtN;
  logic       memWrDriveEn, dataOutDisN, phantomN, keyReadyN;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  tgt_step_ctrl #(
    .CLK_PERIOD_NS (CLK_NS),
    .PULSE_CYCLES  (PULSE)
  ) u_tgt_step_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlReg      (ctrlReg),
    .readyOut     (readyOut),
    .jamN         (jamN),
    .dioDriveEn   (dioDriveEn),
    .tgtResetN    (tgtResetN),
    .wrProtN      (wrProtN),
    .memWrDriveEn (memWrDriveEn),
    .dataOutDisN  (dataOutDisN),
    .phantomN     (phantomN),
    .keyReadyN    (keyReadyN)
  );

  function automatic logic [8:0] outs();
    return {readyOut, jamN, dioDriveEn, tgtResetN, wrProtN,
            memWrDriveEn, dataOutDisN, phantomN, keyReadyN};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] c);
    @(negedge clk);
    ctrlReg = c;
    @(negedge clk);
  endtask

  // Counts ready-high samples over a window while optionally re-stepping mid pulse.
  task automatic countPulse(input bit restep, output int cnt);
    cnt = 0;
    for (int i = 0; i < PULSE + 6; i++) begin
      @(negedge clk);
      if (readyOut) cnt++;
      if (restep && i == 4) ctrlReg = 8'hFC;
      if (restep && i == 6) ctrlReg = 8'hFE;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 in reset", 32'(outs()), 32'h1B7);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'(outs()), 32'h1B7);

    // R12: configured pulse inside the window
    check("R12 window", 32'((PULSE * CLK_NS > 500) && (PULSE * CLK_NS < 1000)), 32'd1);

    // Vector walk: R2 R7 R8 R9 R10 R11
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v][16:9]);
      check("R2/R7/R8/R9/R10/R11 vector", 32'(outs()), 32'(VECS[v][8:0]));
    end

    // R13: no change before the edge, change after it
    @(negedge clk);
    ctrlReg = 8'hFC;
    #1;
    check("R13 before edge", 32'(readyOut), 32'd1);
    @(negedge clk);
    check("R13 after edge", 32'(readyOut), 32'd0);

    // R3: single step pulse length
    @(negedge clk);
    ctrlReg = 8'hFE;
    countPulse(1'b0, cnt);
    check("R3 pulse length", 32'(cnt), 32'(PULSE));
    check("R3 low after pulse", 32'(readyOut), 32'd0);

    // R6: held step bit then falling step bit start nothing
    apply(8'hFC);
    countPulse(1'b0, cnt);
    check("R6 no pulse on fall or hold", 32'(cnt), 32'd0);

    // R5: re-step during a pulse is ignored
    @(negedge clk);
    ctrlReg = 8'hFE;
    countPulse(1'b1, cnt);
    check("R5 pulse unchanged", 32'(cnt), 32'(PULSE));

    // R4: step edge while running, then halt with step held
    apply(8'hFD);
    apply(8'hFF);
    check("R4 running ready", 32'(readyOut), 32'd1);
    @(negedge clk);
    ctrlReg = 8'hFE;
    countPulse(1'b0, cnt);
    check("R4 no pulse after halt", 32'(cnt), 32'd0);

    // R4: run and step rising together also ignored
    apply(8'hFC);
    @(negedge clk);
    ctrlReg = 8'hFF;
    @(negedge clk);
    ctrlReg = 8'hFE;
    countPulse(1'b0, cnt);
    check("R4 simultaneous rise ignored", 32'(cnt), 32'd0);

    // R11: keyboard strobe rising edge
    apply(8'h7C);
    check("R11 key low", 32'(keyReadyN), 32'd0);
    apply(8'hFC);
    check("R11 key high", 32'(keyReadyN), 32'd1);

    // R1: reset mid pulse returns to free run
    @(negedge clk);
    ctrlReg = 8'hFE;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    ctrlReg = 8'hFF;
    @(negedge clk);
    check("R1 reset mid pulse", 32'(outs()), 32'h1B7);
    rstN = 1'b1;
    apply(8'hFC);
    check("R1 no pending pulse", 32'(readyOut), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

endmodule